// File: doc/BRIEF.md
# External SRAM Word Access Controller

This block is a bus master that moves 16-bit words between an on-chip client and a byte-wide asynchronous static RAM. The client places an address and, for stores, two data bytes on its inputs, then raises a one-cycle read or write command. The controller turns each word into a fixed sequence on the memory pins. First comes one address cycle, in which the latch-enable pulse captures the low address byte from the shared address/data port while the high address byte sits on its own port. Two byte cycles follow, each with a programmable number of strobe cycles. The byte-select line is 0 for the first byte cycle and 1 for the second. After a read, an optional bus-release cycle and one turnaround cycle complete the word.

The first byte of a word always belongs to the high data register and the second to the low data register. The wait setting is a 3-bit field. Its effective strobe length RAT is the field value plus one, so it runs from 1 to 8 cycles. The read data registers have no interlock. The client polls a busy level or a done flag before it uses them. A command that arrives while the block is busy is dropped, and a sticky error flag is raised.

Top module: `sram_word_ctrl`

## Requirements
- R1: After reset: busy_o=0, done_o=0, err_o=0, rd_n_o=1, wr_n_o=1, ale_o=0, ad_oe_o=0, rdata_hi_o=0, rdata_lo_o=0.
- R2: A read fetches two bytes. The first is fetched with a0_o=0 and lands in rdata_hi_o. The second is fetched with a0_o=1 and lands in rdata_lo_o. rd_n_o is low for exactly 2*RAT cycles per read, where RAT = cfg_wait_i + 1.
- R3: rdata_hi_o takes its new value RAT+1 clock edges after the edge that accepts the read command, and not one edge earlier.
- R4: rdata_lo_o takes its new value 2*(RAT+1) edges after the accepting edge, and not one edge earlier. The data registers never change while the block is idle.
- R5: After an accepted read, busy_o stays high for 2*(RAT+1)+cfg_release_i+1 cycles. A write has no release cycle. A command presented in the last busy cycle is refused, and the same command presented in the following cycle is accepted.
- R6: In the cycle right after acceptance, ale_o=1 and ad_oe_o=1. ad_o then carries address bits 7:0, ah_o carries address bits 15:8, a0_o=0, and both strobes are high.
- R7: A write drives the high data byte with a0_o=0 and then the low data byte with a0_o=1. Each byte is driven with ad_oe_o=1 while wr_n_o is low for RAT cycles, for a total of 2*RAT low cycles.
- R8: rd_n_o and wr_n_o are never low together. ad_oe_o is low in every cycle in which rd_n_o is low, and it stays low until a read returns to idle.
- R9: A command presented while busy_o=1, or a read and a write presented together, is ignored: the running access and the data registers are unaffected. Either case sets err_o, which then stays 1 until reset.
- R10: done_o is 0 from acceptance of a command until the access returns to idle, and then it is 1.
- R11: The wait and release settings are sampled when a command is accepted. Changing them during an access does not alter its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 16 | Word address for the next command |
| wdata_hi_i | input | 8 | High data byte for a write |
| wdata_lo_i | input | 8 | Low data byte for a write |
| rd_cmd_i | input | 1 | Read command, sampled when idle |
| wr_cmd_i | input | 1 | Write command, sampled when idle |
| cfg_wait_i | input | 3 | Strobe wait setting (RAT = value + 1) |
| cfg_release_i | input | 1 | Extra bus-release cycle after reads |
| rdata_hi_o | output | 8 | First byte fetched by the last read |
| rdata_lo_o | output | 8 | Second byte fetched by the last read |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | Last access finished |
| err_o | output | 1 | Sticky: a command was dropped |
| ad_o | output | 8 | Multiplexed low address / write data |
| ad_i | input | 8 | Read data from memory |
| ad_oe_o | output | 1 | Drive enable for ad_o |
| ah_o | output | 8 | High address byte |
| ale_o | output | 1 | Address latch enable |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| a0_o | output | 1 | Byte select within the word |

## Verification
If the wait counter or the phase register is corrupted, the effect reaches the pins within the same word access. A strobe ends early or late, a0_o flips at the wrong point, or a data register loads one edge off its RAT-derived slot. For that reason the checks sample the registers on the edge before each expected load and on the load edge itself. A wrong busy or done state is visible in the cycle that ends the access, because a command placed there must be refused and placed one cycle later must be accepted. A corrupted error or acceptance path shows up one cycle after an intruding command, as a missing sticky flag or as a disturbed strobe sequence and stored data.

// File: rtl/sram_word_pkg.sv
package sram_word_pkg;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int WAIT_W = 3;
    localparam int AHI_W  = ADDR_W - BYTE_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_STROBE,
        PH_GAP,
        PH_RELEASE,
        PH_TURN
    } phase_e;

    // captured command
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
        logic [WAIT_W-1:0] wait_cfg;
        logic              rel;
        logic              wr;
    } req_t;

    // sequencer state
    typedef struct packed {
        phase_e            ph;
        logic              sel;
        logic [WAIT_W-1:0] cnt;
    } seq_t;

    // pin-level control decoded from the sequencer
    typedef struct packed {
        logic ale;
        logic rd_n;
        logic wr_n;
        logic a0;
        logic oe;
    } pin_ctl_t;

    function automatic logic strobe_last(input seq_t s);
        return (s.ph == PH_STROBE) && (s.cnt == '0);
    endfunction

    function automatic logic [AHI_W-1:0] addr_high(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:BYTE_W];
    endfunction

endpackage

// File: rtl/sram_cmd_accept.sv
module sram_cmd_accept
    import sram_word_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              idle,
    input  logic              rd_cmd,
    input  logic              wr_cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata_hi,
    input  logic [BYTE_W-1:0] wdata_lo,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              cfg_release,
    output logic              accept,
    output req_t              req,
    output logic              err
);

    logic any_cmd;
    logic refuse;

    assign any_cmd = rd_cmd | wr_cmd;
    assign accept  = idle & (rd_cmd ^ wr_cmd);
    assign refuse  = any_cmd & ~accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            req <= '0;
            err <= 1'b0;
        end else begin
            if (accept) begin
                req.addr     <= addr;
                req.hi       <= wdata_hi;
                req.lo       <= wdata_lo;
                req.wait_cfg <= cfg_wait;
                req.rel      <= cfg_release & rd_cmd;
                req.wr       <= wr_cmd;
            end
            if (refuse) begin
                err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
    import sram_word_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  req_t req,
    output seq_t st,
    output logic idle,
    output logic cap_hi,
    output logic cap_lo,
    output logic done
);

    seq_t nxt;

    assign idle   = (st.ph == PH_IDLE);
    assign cap_hi = strobe_last(st) & ~st.sel & ~req.wr;
    assign cap_lo = strobe_last(st) &  st.sel & ~req.wr;

    always_comb begin
        nxt = st;
        unique case (st.ph)
            PH_IDLE: begin
                if (accept) begin
                    nxt.ph  = PH_ADDR;
                    nxt.sel = 1'b0;
                    nxt.cnt = '0;
                end
            end
            PH_ADDR: begin
                nxt.ph  = PH_STROBE;
                nxt.cnt = req.wait_cfg;
            end
            PH_STROBE: begin
                if (st.cnt != '0) begin
                    nxt.cnt = st.cnt - 1'b1;
                end else if (!st.sel) begin
                    nxt.ph  = PH_GAP;
                    nxt.sel = 1'b1;
                end else if (req.rel) begin
                    nxt.ph = PH_RELEASE;
                end else begin
                    nxt.ph = PH_TURN;
                end
            end
            PH_GAP: begin
                nxt.ph  = PH_STROBE;
                nxt.cnt = req.wait_cfg;
            end
            PH_RELEASE: nxt.ph = PH_TURN;
            PH_TURN: begin
                nxt.ph  = PH_IDLE;
                nxt.sel = 1'b0;
            end
            default: nxt.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.ph  <= PH_IDLE;
            st.sel <= 1'b0;
            st.cnt <= '0;
            done   <= 1'b0;
        end else begin
            st <= nxt;
            if (accept) begin
                done <= 1'b0;
            end else if (st.ph == PH_TURN) begin
                done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sram_bus_drive.sv
module sram_bus_drive
    import sram_word_pkg::*;
(
    input  seq_t              st,
    input  req_t              req,
    output pin_ctl_t          ctl,
    output logic [BYTE_W-1:0] ad,
    output logic [AHI_W-1:0]  ah
);

    logic in_byte;

    assign in_byte = (st.ph == PH_STROBE) || (st.ph == PH_GAP);

    always_comb begin
        ctl.ale  = (st.ph == PH_ADDR);
        ctl.rd_n = ~((st.ph == PH_STROBE) && !req.wr);
        ctl.wr_n = ~((st.ph == PH_STROBE) &&  req.wr);
        ctl.a0   = in_byte & st.sel;
        ctl.oe   = (st.ph == PH_ADDR) || (in_byte && req.wr);
    end

    always_comb begin
        if (st.ph == PH_ADDR) begin
            ad = req.addr[BYTE_W-1:0];
        end else if (in_byte && req.wr) begin
            ad = st.sel ? req.lo : req.hi;
        end else begin
            ad = '0;
        end
    end

    assign ah = addr_high(req.addr);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture
    import sram_word_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_hi,
    input  logic              cap_lo,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] hi,
    output logic [BYTE_W-1:0] lo
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi <= '0;
            lo <= '0;
        end else begin
            if (cap_hi) hi <= din;
            if (cap_lo) lo <= din;
        end
    end

endmodule

// File: rtl/sram_word_ctrl.sv
module sram_word_ctrl
    import sram_word_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_hi_i,
    input  logic [BYTE_W-1:0] wdata_lo_i,
    input  logic              rd_cmd_i,
    input  logic              wr_cmd_i,
    input  logic [WAIT_W-1:0] cfg_wait_i,
    input  logic              cfg_release_i,
    output logic [BYTE_W-1:0] rdata_hi_o,
    output logic [BYTE_W-1:0] rdata_lo_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [BYTE_W-1:0] ad_o,
    input  logic [BYTE_W-1:0] ad_i,
    output logic              ad_oe_o,
    output logic [AHI_W-1:0]  ah_o,
    output logic              ale_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic              a0_o
);

    logic     accept;
    logic     idle;
    logic     cap_hi;
    logic     cap_lo;
    req_t     req;
    seq_t     st;
    pin_ctl_t ctl;

    sram_cmd_accept u_accept (
        .clk         (clk),
        .rst         (rst),
        .idle        (idle),
        .rd_cmd      (rd_cmd_i),
        .wr_cmd      (wr_cmd_i),
        .addr        (addr_i),
        .wdata_hi    (wdata_hi_i),
        .wdata_lo    (wdata_lo_i),
        .cfg_wait    (cfg_wait_i),
        .cfg_release (cfg_release_i),
        .accept      (accept),
        .req         (req),
        .err         (err_o)
    );

    sram_phase_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .req    (req),
        .st     (st),
        .idle   (idle),
        .cap_hi (cap_hi),
        .cap_lo (cap_lo),
        .done   (done_o)
    );

    sram_bus_drive u_drive (
        .st  (st),
        .req (req),
        .ctl (ctl),
        .ad  (ad_o),
        .ah  (ah_o)
    );

    sram_rd_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .cap_hi (cap_hi),
        .cap_lo (cap_lo),
        .din    (ad_i),
        .hi     (rdata_hi_o),
        .lo     (rdata_lo_o)
    );

    assign busy_o  = ~idle;
    assign ale_o   = ctl.ale;
    assign rd_n_o  = ctl.rd_n;
    assign wr_n_o  = ctl.wr_n;
    assign a0_o    = ctl.a0;
    assign ad_oe_o = ctl.oe;

endmodule

// File: rtl/sram_word_ctrl_chk.sv
module sram_word_ctrl_chk
    import sram_word_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rd_cmd_i,
    input logic              wr_cmd_i,
    input logic [BYTE_W-1:0] rdata_hi_o,
    input logic [BYTE_W-1:0] rdata_lo_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic              ad_oe_o,
    input logic              ale_o,
    input logic              rd_n_o,
    input logic              wr_n_o,
    input logic              a0_o
);

    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n_o && !wr_n_o));

    assert_oe_off_read_R8: assert property (@(posedge clk) disable iff (rst)
        !rd_n_o |-> !ad_oe_o);

    assert_ale_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        ale_o |-> (rd_n_o && wr_n_o && !a0_o && ad_oe_o));

    assert_accept_ale_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && (rd_cmd_i ^ wr_cmd_i)) |=> (ale_o && busy_o));

    assert_err_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && (rd_cmd_i || wr_cmd_i)) |=> err_o);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    assert_done_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && (rd_cmd_i ^ wr_cmd_i)) |=> !done_o);

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !busy_o |=> ($stable(rdata_hi_o) && $stable(rdata_lo_o)));

endmodule

bind sram_word_ctrl sram_word_ctrl_chk u_chk (.*);

// File: tb/sram_word_ctrl_bench.sv
module sram_word_ctrl_bench;
    import sram_word_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] addr_i = '0;
    logic [7:0]  wdata_hi_i = '0, wdata_lo_i = '0;
    logic rd_cmd_i = 1'b0, wr_cmd_i = 1'b0;
    logic [2:0] cfg_wait_i = '0;
    logic cfg_release_i = 1'b0;
    logic [7:0] rdata_hi_o, rdata_lo_o, ad_o, ad_i, ah_o;
    logic busy_o, done_o, err_o, ad_oe_o, ale_o, rd_n_o, wr_n_o, a0_o;

    always #2 clk = ~clk;

    sram_word_ctrl u_sram_word_ctrl (.*);

    // memory model
    logic [7:0] mem [0:255];
    logic [7:0] shadow [0:255];
    logic [7:0] lat_lo = '0;
    logic [7:0] cur_idx;
    assign cur_idx = {ah_o[3:0], lat_lo[2:0], a0_o};
    assign ad_i = !rd_n_o ? mem[cur_idx] : 8'hEE;
    always @(posedge clk) begin
        if (ale_o) lat_lo <= ad_o;
        if (!wr_n_o) mem[cur_idx] <= ad_o;
    end

    int checks = 0, errors = 0, cycles = 0, overlap_bad = 0;
    bit finished = 1'b0;
    logic [7:0] last_hi = '0, last_lo = '0;

    function automatic logic [7:0] idx_of(input logic [15:0] a, input bit b);
        return {a[11:8], a[2:0], b};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (!rd_n_o && !wr_n_o) overlap_bad++;
            if (!rd_n_o && ad_oe_o) overlap_bad++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic run_access(input bit is_wr, input logic [15:0] a, input logic [7:0] dhi,
                              input logic [7:0] dlo, input int wt, input bit rel,
                              input bit intrude, input bit chg_cfg, input bit early_next);
        int rat = wt + 1;
        int relc = is_wr ? 0 : int'(rel);
        int last = 2 * rat + 3 + relc;
        int lowcnt = 0;
        int bad = 0;
        logic [7:0] ehi = shadow[idx_of(a, 1'b0)];
        logic [7:0] elo = shadow[idx_of(a, 1'b1)];
        addr_i = a; wdata_hi_i = dhi; wdata_lo_i = dlo;
        cfg_wait_i = 3'(wt); cfg_release_i = rel;
        if (is_wr) wr_cmd_i = 1'b1; else rd_cmd_i = 1'b1;
        step();
        rd_cmd_i = 1'b0; wr_cmd_i = 1'b0;
        if (chg_cfg) begin
            cfg_wait_i = ~3'(wt); cfg_release_i = ~rel;
        end
        for (int j = 0; j <= last; j++) begin
            if (j > 0) step();
            if (j == 0) begin
                chk(ale_o && ad_oe_o && rd_n_o && wr_n_o && !a0_o, "R6 address cycle controls",
                    {ale_o, ad_oe_o, rd_n_o, wr_n_o, a0_o}, 5'b11110);
                chk(ad_o == a[7:0] && ah_o == a[15:8], "R6 address bytes", {ah_o, ad_o}, a);
                chk(busy_o && !done_o, "R10 done cleared on accept", {busy_o, done_o}, 2'b10);
            end
            if (!is_wr && !rd_n_o) begin
                lowcnt++;
                if (a0_o != (j > rat)) bad++;
            end
            if (is_wr && !wr_n_o) begin
                lowcnt++;
                if (!ad_oe_o || a0_o != (j > rat) || ad_o != ((j > rat) ? dlo : dhi)) bad++;
            end
            if (!is_wr) begin
                if (j == rat)         chk(rdata_hi_o == last_hi, "R3 high byte not early", rdata_hi_o, last_hi);
                if (j == rat + 1)     chk(rdata_hi_o == ehi, "R3 R2 high byte loaded", rdata_hi_o, ehi);
                if (j == 2 * rat + 1) chk(rdata_lo_o == last_lo, "R4 low byte not early", rdata_lo_o, last_lo);
                if (j == 2 * rat + 2) chk(rdata_lo_o == elo, "R4 R2 low byte loaded", rdata_lo_o, elo);
            end
            if (intrude && j == 2) rd_cmd_i = 1'b1;
            if (intrude && j == 3) rd_cmd_i = 1'b0;
            if (j == last - 1) begin
                chk(busy_o == 1'b1, "R5 busy in last cycle", busy_o, 1);
                if (early_next) rd_cmd_i = 1'b1;
            end
            if (j == last) chk(!busy_o && done_o, "R5 R10 idle and done", {busy_o, done_o}, 2'b01);
        end
        if (is_wr) begin
            chk(lowcnt == 2 * rat, "R7 write strobe cycles", lowcnt, 2 * rat);
            chk(bad == 0, "R7 write byte order and data", bad, 0);
            chk(rdata_hi_o == last_hi && rdata_lo_o == last_lo, "R9 read regs untouched by write",
                {rdata_hi_o, rdata_lo_o}, {last_hi, last_lo});
            shadow[idx_of(a, 1'b0)] = dhi;
            shadow[idx_of(a, 1'b1)] = dlo;
        end else begin
            chk(lowcnt == 2 * rat, "R2 read strobe cycles", lowcnt, 2 * rat);
            chk(bad == 0, "R2 a0 order", bad, 0);
            last_hi = ehi; last_lo = elo;
        end
    endtask

    task automatic test_reset();
        chk(!busy_o && !done_o && !err_o, "R1 status", {busy_o, done_o, err_o}, 0);
        chk(rd_n_o && wr_n_o && !ale_o && !ad_oe_o, "R1 pins", {rd_n_o, wr_n_o, ale_o, ad_oe_o}, 4'b1100);
        chk(rdata_hi_o == 0 && rdata_lo_o == 0, "R1 data", {rdata_hi_o, rdata_lo_o}, 0);
    endtask

    task automatic test_reads();
        run_access(1'b0, 16'h0107, 8'h00, 8'h00, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        run_access(1'b0, 16'h0A05, 8'h00, 8'h00, 7, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic test_write_back();
        run_access(1'b1, 16'h0C03, 8'hA5, 8'h5A, 2, 1'b1, 1'b0, 1'b0, 1'b0);
        run_access(1'b0, 16'h0C03, 8'h00, 8'h00, 1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(rdata_hi_o == 8'hA5 && rdata_lo_o == 8'h5A, "R7 readback", {rdata_hi_o, rdata_lo_o}, 16'hA55A);
    endtask

    task automatic test_cfg_change();
        // R11: settings altered after acceptance must not move the loads
        run_access(1'b0, 16'h0301, 8'h00, 8'h00, 0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk(err_o == 1'b0, "R9 no error before any refusal", err_o, 0);
    endtask

    task automatic test_spacing();
        run_access(1'b0, 16'h0206, 8'h00, 8'h00, 1, 1'b1, 1'b0, 1'b0, 1'b1);
        chk(err_o == 1'b1, "R5 R9 command in last busy cycle refused", err_o, 1);
        // rd_cmd_i still high: accepted on the next edge
        run_access(1'b0, 16'h0E02, 8'h00, 8'h00, 1, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic test_intrude();
        run_access(1'b1, 16'h0504, 8'h3E, 8'hC1, 1, 1'b0, 1'b1, 1'b0, 1'b0);
        chk(err_o == 1'b1, "R9 sticky after intrusion", err_o, 1);
        run_access(1'b0, 16'h0504, 8'h00, 8'h00, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(rdata_hi_o == 8'h3E && rdata_lo_o == 8'hC1, "R9 write intact", {rdata_hi_o, rdata_lo_o}, 16'h3EC1);
    endtask

    task automatic test_both();
        rd_cmd_i = 1'b1; wr_cmd_i = 1'b1;
        step();
        rd_cmd_i = 1'b0; wr_cmd_i = 1'b0;
        chk(!busy_o && rd_n_o && wr_n_o && !ale_o, "R9 read+write together ignored",
            {busy_o, rd_n_o, wr_n_o, ale_o}, 4'b0110);
        step();
        chk(!busy_o && err_o, "R9 still idle with error", {busy_o, err_o}, 2'b01);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i) ^ 8'h3C;
            shadow[i] = 8'(i) ^ 8'h3C;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_reads();
        test_write_back();
        test_cfg_change();
        test_spacing();
        test_intrude();
        test_both();
        chk(overlap_bad == 0, "R8 strobe overlap or drive during read", overlap_bad, 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule